// File: doc/BRIEF.md
# Dual-Channel Serial DAC Control Logic

This block is the digital front end of a two-channel 12-bit voltage DAC. A host writes 16-bit command words over a three-wire serial port: an active-low frame select, a serial clock and a data line. The block keeps two registers per channel. The input register is the staging copy and the DAC register is the code that drives the converter. Commands fill the input registers, copy them into the DAC registers, or do both at once. A separate active-low load pin copies both staging registers to the outputs without any serial traffic. The block also tracks per-channel shutdown with a selectable output termination and a global bias power-down. After a channel wakes up, it raises a settle flag for a programmable number of clock cycles.

All four pins are brought into the system clock domain through two flops each. Edges are then found on the synchronized copies. A frame FSM receives each word. It idles in `RX_IDLE`. A falling select moves it to `RX_SHIFT`, where it counts bits on rising serial-clock edges. A rising select leads to one of two places:
- `RX_EXEC`, for a clean 16-bit word with a zero sub-bit. This state lasts one cycle and hands the word to the register bank.
- Back to `RX_IDLE`, for any other word, which is aborted.

From `RX_EXEC` the FSM returns to `RX_IDLE`, or goes to `RX_SHIFT` if a new frame has already begun.

Top module: `dual_dac_ctrl`

## Requirements
- R1: A frame is 16 bits, most significant first: control code in bits 15:13, 12-bit data in bits 12:1, sub-bit in bit 0. The word acts once, after the synchronized rising edge of the select line.
- R2: A frame with a bit count other than 16, or with sub-bit 1, changes nothing. Control code 000 and extended sub-codes 110 and 111 also change nothing.
- R3: Code 001 writes the data to input register A and code 101 writes it to input register B. Neither changes any output code or power state.
- R4: Code 010 (or 110) writes the data to input register A (or B). It then sets both DAC registers from the updated input registers.
- R5: Code 011 writes the data to both input and both DAC registers. Code 100 copies both input registers into the DAC registers.
- R6: Code 111 selects an extended command by data bits 11:9. Sub-code 001 copies input A to DAC A only, and 011 copies input B to DAC B only.
- R7: Extended 000 shuts both channels down, taking A's termination bit from data bit 8 and B's from data bit 7. Extended 100 shuts A down with data bit 8, and 101 shuts B down with data bit 8. A termination flag of 0 means the ~1 kΩ load and 1 means the ~200 kΩ load.
- R8: Extended 010 shuts both channels down with bits as in R7 and raises `bias_off`. Any channel start-up clears `bias_off`.
- R9: Every command that writes a DAC register powers that channel up.
- R10: A synchronized falling edge on `load_n` copies both input registers into the DAC registers and powers both channels up.
- R11: If a load-pin edge and a command act in the same cycle, the pin copies the input registers as the command left them, and its power-up wins.
- R12: When a channel leaves shutdown, `settle_busy` is high for exactly SETTLE_FULL cycles if `bias_off` was set, and SETTLE_DAC cycles otherwise. A write to a channel that is already up raises no flag.
- R13: After reset: all codes are zero, both channels are down with flag 0, `bias_off` is 0 and `settle_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial clock, data taken on rising edge |
| sdin | input | 1 | Serial data |
| load_n | input | 1 | Asynchronous load-both pin, active low |
| code_a | output | 12 | DAC register A |
| code_b | output | 12 | DAC register B |
| down_a | output | 1 | Channel A shut down |
| down_b | output | 1 | Channel B shut down |
| lite_a | output | 1 | Channel A termination: 0 ~1 kΩ, 1 ~200 kΩ |
| lite_b | output | 1 | Channel B termination: 0 ~1 kΩ, 1 ~200 kΩ |
| bias_off | output | 1 | Main bias powered down |
| settle_busy | output | 1 | Output still settling after a start-up |

## Verification
A serial command and a load-pin edge can act on the registers in the same cycle. The bench provokes this by dropping `load_n` exactly one system clock after it raises `cs_n`. Both signals pass through equal synchronizer depth, so the load edge lands in the cycle the FSM spends in `RX_EXEC`. The collision is judged two ways. With a load-only command, the output must show the freshly written input value. With a power-down command, both channels must end up powered, carrying the command's new termination flags.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_LD_A     = 3'd1,
        OP_LD_A_UPD = 3'd2,
        OP_LD_ALL   = 3'd3,
        OP_UPD_ALL  = 3'd4,
        OP_LD_B     = 3'd5,
        OP_LD_B_UPD = 3'd6,
        OP_EXT      = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        EX_PD_BOTH = 3'd0,
        EX_UPD_A   = 3'd1,
        EX_PD_FULL = 3'd2,
        EX_UPD_B   = 3'd3,
        EX_PD_A    = 3'd4,
        EX_PD_B    = 3'd5,
        EX_RSV6    = 3'd6,
        EX_RSV7    = 3'd7
    } ext_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_EXEC  = 2'd2
    } rx_state_e;

endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
    parameter int          N_SIG   = 4,
    parameter int          STAGES  = 2,
    parameter logic [N_SIG-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] async_i,
    output logic [N_SIG-1:0] sync_o
);

    for (genvar g = 0; g < N_SIG; g++) begin : g_sig
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], async_i[g]};
        end
        assign sync_o[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
    import dac_ctrl_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              din_s,
    output logic              exec_o,
    output logic [WORD_W-1:0] word_o
);

    localparam int CNT_MAX = WORD_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    rx_state_e         state, state_nx;
    logic              cs_q, sclk_q;
    logic              cs_rise, cs_fall, sclk_rise;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] sr;
    logic              frame_ok;

    assign cs_rise   = cs_s & ~cs_q;
    assign cs_fall   = ~cs_s & cs_q;
    assign sclk_rise = sclk_s & ~sclk_q;
    assign frame_ok  = (cnt == CNT_W'(WORD_W)) && !sr[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (cs_fall) state_nx = RX_SHIFT;
            RX_SHIFT: if (cs_rise) state_nx = frame_ok ? RX_EXEC : RX_IDLE;
            RX_EXEC:  state_nx = cs_fall ? RX_SHIFT : RX_IDLE;
            default:  state_nx = RX_IDLE;
        endcase
    end

    // edge history, shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
            cnt    <= '0;
            sr     <= '0;
        end else begin
            cs_q   <= cs_s;
            sclk_q <= sclk_s;
            if (cs_fall) begin
                cnt <= '0;
                sr  <= '0;
            end else if (state == RX_SHIFT && sclk_rise) begin
                sr <= {sr[WORD_W-2:0], din_s};
                if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        exec_o = (state == RX_EXEC);
        word_o = sr;
    end

endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
    import dac_ctrl_pkg::*;
#(
    parameter int DATA_W = 12,
    localparam int WORD_W = DATA_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              ld_s,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic              down_a,
    output logic              down_b,
    output logic              lite_a,
    output logic              lite_b,
    output logic              bias_off,
    output logic              start_o,
    output logic              start_full_o
);

    op_e               op;
    ext_e              ext;
    logic [DATA_W-1:0] data;
    logic              pa, pb;
    logic              ld_q, ld_fall;

    logic [DATA_W-1:0] in_a, in_b, nx_in_a, nx_in_b, nx_dac_a, nx_dac_b;
    logic              nx_dn_a, nx_dn_b, nx_lt_a, nx_lt_b, nx_bias;

    assign op      = op_e'(word_i[WORD_W-1 -: 3]);
    assign data    = word_i[DATA_W:1];
    assign ext     = ext_e'(data[DATA_W-1 -: 3]);
    assign pa      = data[DATA_W-4];
    assign pb      = data[DATA_W-5];
    assign ld_fall = ld_q & ~ld_s;

    always_comb begin
        nx_in_a  = in_a;    nx_in_b  = in_b;
        nx_dac_a = code_a;  nx_dac_b = code_b;
        nx_dn_a  = down_a;  nx_dn_b  = down_b;
        nx_lt_a  = lite_a;  nx_lt_b  = lite_b;
        nx_bias  = bias_off;
        if (exec_i) begin
            unique case (op)
                OP_NOP: ;
                OP_LD_A: nx_in_a = data;
                OP_LD_B: nx_in_b = data;
                OP_LD_A_UPD: begin
                    nx_in_a = data; nx_dac_a = data; nx_dac_b = in_b;
                    nx_dn_a = 1'b0; nx_dn_b = 1'b0;
                end
                OP_LD_B_UPD: begin
                    nx_in_b = data; nx_dac_b = data; nx_dac_a = in_a;
                    nx_dn_a = 1'b0; nx_dn_b = 1'b0;
                end
                OP_LD_ALL: begin
                    nx_in_a = data; nx_in_b = data;
                    nx_dac_a = data; nx_dac_b = data;
                    nx_dn_a = 1'b0; nx_dn_b = 1'b0;
                end
                OP_UPD_ALL: begin
                    nx_dac_a = in_a; nx_dac_b = in_b;
                    nx_dn_a = 1'b0; nx_dn_b = 1'b0;
                end
                OP_EXT: begin
                    unique case (ext)
                        EX_PD_BOTH: begin
                            nx_dn_a = 1'b1; nx_dn_b = 1'b1;
                            nx_lt_a = pa;   nx_lt_b = pb;
                        end
                        EX_PD_FULL: begin
                            nx_dn_a = 1'b1; nx_dn_b = 1'b1;
                            nx_lt_a = pa;   nx_lt_b = pb;
                            nx_bias = 1'b1;
                        end
                        EX_UPD_A: begin nx_dac_a = in_a; nx_dn_a = 1'b0; end
                        EX_UPD_B: begin nx_dac_b = in_b; nx_dn_b = 1'b0; end
                        EX_PD_A:  begin nx_dn_a = 1'b1; nx_lt_a = pa; end
                        EX_PD_B:  begin nx_dn_b = 1'b1; nx_lt_b = pa; end
                        EX_RSV6, EX_RSV7: ;
                    endcase
                end
            endcase
        end
        if (ld_fall) begin
            nx_dac_a = nx_in_a; nx_dac_b = nx_in_b;
            nx_dn_a  = 1'b0;    nx_dn_b  = 1'b0;
        end
        if (!nx_dn_a || !nx_dn_b) nx_bias = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_a <= '0; in_b <= '0; code_a <= '0; code_b <= '0;
            down_a <= 1'b1; down_b <= 1'b1; lite_a <= 1'b0; lite_b <= 1'b0;
            bias_off <= 1'b0; ld_q <= 1'b1;
        end else begin
            in_a <= nx_in_a; in_b <= nx_in_b;
            code_a <= nx_dac_a; code_b <= nx_dac_b;
            down_a <= nx_dn_a; down_b <= nx_dn_b;
            lite_a <= nx_lt_a; lite_b <= nx_lt_b;
            bias_off <= nx_bias; ld_q <= ld_s;
        end
    end

    assign start_o      = (down_a & ~nx_dn_a) | (down_b & ~nx_dn_b);
    assign start_full_o = bias_off;

endmodule

// File: rtl/dac_settle_timer.sv
module dac_settle_timer #(
    parameter int SETTLE_DAC  = 20,
    parameter int SETTLE_FULL = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic full_i,
    output logic busy_o
);

    localparam int MAXC = (SETTLE_FULL > SETTLE_DAC) ? SETTLE_FULL : SETTLE_DAC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (start_i)   cnt <= full_i ? CW'(SETTLE_FULL) : CW'(SETTLE_DAC);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign busy_o = (cnt != '0);

endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl #(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_DAC  = 20,
    parameter int SETTLE_FULL = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              load_n,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic              down_a,
    output logic              down_b,
    output logic              lite_a,
    output logic              lite_b,
    output logic              bias_off,
    output logic              settle_busy
);

    localparam int WORD_W = DATA_W + 4;

    logic [3:0]        pins_s;
    logic              exec;
    logic [WORD_W-1:0] word;
    logic              start, start_full;

    dac_in_sync #(.N_SIG(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({load_n, sdin, sclk, cs_n}),
        .sync_o(pins_s)
    );

    dac_frame_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .cs_s(pins_s[0]), .sclk_s(pins_s[1]), .din_s(pins_s[2]),
        .exec_o(exec), .word_o(word)
    );

    dac_reg_bank #(.DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .exec_i(exec), .word_i(word), .ld_s(pins_s[3]),
        .code_a(code_a), .code_b(code_b),
        .down_a(down_a), .down_b(down_b),
        .lite_a(lite_a), .lite_b(lite_b),
        .bias_off(bias_off),
        .start_o(start), .start_full_o(start_full)
    );

    dac_settle_timer #(.SETTLE_DAC(SETTLE_DAC), .SETTLE_FULL(SETTLE_FULL)) u_settle (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .full_i(start_full),
        .busy_o(settle_busy)
    );

endmodule

// File: rtl/dac_ctrl_checker.sv
module dac_ctrl_checker #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] code_a,
    input logic [DATA_W-1:0] code_b,
    input logic              down_a,
    input logic              down_b,
    input logic              bias_off,
    input logic              settle_busy
);

    AST_CODE_A_CHG_UP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_a) |-> !down_a);                                   // R9
    AST_CODE_B_CHG_UP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_b) |-> !down_b);                                   // R9
    AST_BIAS_OFF_ALL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        bias_off |-> (down_a && down_b));                                // R8
    AST_BIAS_BACK_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bias_off) |-> (!down_a || !down_b));                       // R8
    AST_SETTLE_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settle_busy) |-> ($fell(down_a) || $fell(down_b)));        // R12

endmodule

bind dual_dac_ctrl dac_ctrl_checker #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .code_a(code_a), .code_b(code_b),
    .down_a(down_a), .down_b(down_b), .bias_off(bias_off),
    .settle_busy(settle_busy)
);

// File: tb/test_dual_dac_ctrl.sv
module test_dual_dac_ctrl;

    localparam int SD = 20;
    localparam int SF = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdin = 1'b0, load_n = 1'b1;
    logic [11:0] code_a, code_b;
    logic down_a, down_b, lite_a, lite_b, bias_off, settle_busy;

    int n_cmp = 0;
    int n_bad = 0;

    logic [11:0] e_in_a, e_in_b, e_dac_a, e_dac_b;
    logic e_dn_a, e_dn_b, e_lt_a, e_lt_b, e_bias;

    always #4 clk = ~clk;

    dual_dac_ctrl #(.SETTLE_DAC(SD), .SETTLE_FULL(SF)) i_dual_dac_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
        .load_n(load_n), .code_a(code_a), .code_b(code_b),
        .down_a(down_a), .down_b(down_b), .lite_a(lite_a), .lite_b(lite_b),
        .bias_off(bias_off), .settle_busy(settle_busy)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        summary();
        $finish;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, "code_a", code_a, e_dac_a);
        chk(req, "code_b", code_b, e_dac_b);
        chk(req, "down_a", down_a, e_dn_a);
        chk(req, "down_b", down_b, e_dn_b);
        chk(req, "lite_a", lite_a, e_lt_a);
        chk(req, "lite_b", lite_b, e_lt_b);
        chk(req, "bias_off", bias_off, e_bias);
        chk(req, "settle_busy", settle_busy, 0);
    endtask

    function automatic logic [15:0] mk(input logic [2:0] op, input logic [11:0] d);
        return {op, d, 1'b0};
    endfunction

    function automatic logic [15:0] mkx(input logic [2:0] ex, input logic pa, input logic pb);
        return {3'b111, ex, pa, pb, 7'd0, 1'b0};
    endfunction

    task automatic model_cmd(input logic [15:0] w);
        logic [2:0] op; logic [11:0] d;
        op = w[15:13]; d = w[12:1];
        case (op)
            3'd1: e_in_a = d;
            3'd5: e_in_b = d;
            3'd2: begin e_in_a = d; e_dac_a = d; e_dac_b = e_in_b; e_dn_a = 0; e_dn_b = 0; end
            3'd6: begin e_in_b = d; e_dac_b = d; e_dac_a = e_in_a; e_dn_a = 0; e_dn_b = 0; end
            3'd3: begin e_in_a = d; e_in_b = d; e_dac_a = d; e_dac_b = d; e_dn_a = 0; e_dn_b = 0; end
            3'd4: begin e_dac_a = e_in_a; e_dac_b = e_in_b; e_dn_a = 0; e_dn_b = 0; end
            3'd7: case (d[11:9])
                3'd0: begin e_dn_a = 1; e_dn_b = 1; e_lt_a = d[8]; e_lt_b = d[7]; end
                3'd2: begin e_dn_a = 1; e_dn_b = 1; e_lt_a = d[8]; e_lt_b = d[7]; e_bias = 1; end
                3'd1: begin e_dac_a = e_in_a; e_dn_a = 0; end
                3'd3: begin e_dac_b = e_in_b; e_dn_b = 0; end
                3'd4: begin e_dn_a = 1; e_lt_a = d[8]; end
                3'd5: begin e_dn_b = 1; e_lt_b = d[8]; end
                default: ;
            endcase
            default: ;
        endcase
        if (!e_dn_a || !e_dn_b) e_bias = 0;
    endtask

    task automatic model_ld();
        e_dac_a = e_in_a; e_dac_b = e_in_b; e_dn_a = 0; e_dn_b = 0; e_bias = 0;
    endtask

    task automatic send_frame(input logic [15:0] w, input int nbits, input bit with_ld, output int busy);
        busy = 0;
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdin = (i < 16) ? w[15-i] : 1'b0;
            sclk = 1'b0; repeat (4) @(negedge clk);
            sclk = 1'b1; repeat (4) @(negedge clk);
        end
        sclk = 1'b0; repeat (4) @(negedge clk);
        cs_n = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (with_ld && i == 0) load_n = 1'b0;
            if (with_ld && i == 4) load_n = 1'b1;
            if (settle_busy) busy++;
        end
    endtask

    task automatic pulse_ld();
        @(negedge clk) load_n = 1'b0;
        repeat (4) @(negedge clk);
        load_n = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic run(input logic [15:0] w, input string req, input int exp_busy);
        int b;
        send_frame(w, 16, 1'b0, b);
        model_cmd(w);
        compare_all(req);
        if (exp_busy >= 0) chk(req, "settle cycles", b, exp_busy);
    endtask

    initial begin
        int b;
        logic [15:0] w;
        int r;
        r = $urandom(32'h1F2E3D4C);
        e_in_a = 0; e_in_b = 0; e_dac_a = 0; e_dac_b = 0;
        e_dn_a = 1; e_dn_b = 1; e_lt_a = 0; e_lt_b = 0; e_bias = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        compare_all("R13");

        run(mk(3'd1, 12'h5A3), "R3", 0);
        run(mkx(3'd1, 0, 0), "R6", SD);
        run(mk(3'd6, 12'h9C1), "R4", SD);
        run(mk(3'd5, 12'h777), "R3", 0);
        run(mkx(3'd3, 0, 0), "R6", 0);
        run(mk(3'd2, 12'h0F0), "R4", 0);

        send_frame(mk(3'd3, 12'hABC), 15, 1'b0, b); compare_all("R2");
        send_frame(mk(3'd3, 12'hABC), 17, 1'b0, b); compare_all("R2");
        send_frame(mk(3'd3, 12'hABC) | 16'h0001, 16, 1'b0, b); compare_all("R2");
        run(mk(3'd0, 12'hFFF), "R2", 0);
        run(mkx(3'd6, 1, 1), "R2", 0);
        run(mkx(3'd7, 1, 1), "R2", 0);

        run(mkx(3'd4, 1, 0), "R7", 0);
        run(mkx(3'd5, 1, 0), "R7", 0);
        run(mkx(3'd0, 0, 1), "R7", 0);
        run(mkx(3'd2, 1, 1), "R8", 0);
        run(mk(3'd3, 12'hFFF), "R5", SF);
        run(mk(3'd1, 12'h321), "R3", 0);
        run(mk(3'd5, 12'h654), "R3", 0);
        run(mk(3'd4, 12'h000), "R5", 0);
        run(mkx(3'd0, 1, 1), "R7", 0);
        run(mkx(3'd1, 0, 0), "R9", SD);

        run(mk(3'd1, 12'h111), "R10", 0);
        run(mk(3'd5, 12'h222), "R10", 0);
        pulse_ld(); model_ld(); compare_all("R10");

        run(mkx(3'd0, 0, 0), "R11", 0);
        run(mk(3'd5, 12'h456), "R11", 0);
        w = mk(3'd1, 12'hABC);
        send_frame(w, 16, 1'b1, b); model_cmd(w); model_ld(); compare_all("R11");
        w = mkx(3'd0, 1, 0);
        send_frame(w, 16, 1'b1, b); model_cmd(w); model_ld(); compare_all("R11");

        for (int k = 0; k < 80; k++) begin
            int nb; bit ld;
            w = 16'($urandom);
            r = $urandom;
            nb = (r % 11 == 0) ? 15 : ((r % 13 == 0) ? 17 : 16);
            if (r % 7 != 0) w[0] = 1'b0;
            ld = ((r >> 8) % 6 == 0);
            send_frame(w, nb, ld, b);
            if (nb == 16 && !w[0]) model_cmd(w);
            if (ld) model_ld();
            compare_all("R1");
        end

        summary();
        $finish;
    end

endmodule